// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

A 16-bit down-counter that is read and written through three register slots on a small register bus. One slot is for control and status, one for the modulus and one for the live count. Count ticks come from the system clock divided by a fixed two and then by a power of two chosen by a 4-bit prescale code. Each tick lowers the count by one. A tick that finds the count at zero is an expiry. An expiry reloads the counter and sets a sticky flag. The interrupt line is high whenever that flag and the interrupt enable are both set.

The counter has two modes. In reload mode it restarts from the modulus. Otherwise it free-runs and restarts from 0xFFFF. With the overwrite option set, a modulus write goes straight into the running count. A control write that only toggles the interrupt enable, or only clears the flag, leaves the count and the prescaler alone. Any other change of configuration restarts both. The debug and doze bits are stored and read back only.

Top module: `pit_timer`

## Requirements
- R1: After reset the control/status slot (offset 0) reads 0x0000, the modulus (offset 2) reads 0xFFFF, the count (offset 4) reads 0xFFFF, and the interrupt is low.
- R2: The control/status word has these fields: bit 0 enable, bit 1 reload mode, bit 2 flag, bit 3 interrupt enable, bit 4 overwrite, bit 5 debug, bit 6 doze, bits 11:8 prescale code. Bits 7 and 15:12 read as 0, and writing 0xFFFF reads back 0x0F7B.
- R3: While enabled, the count falls by one every 2^(code+1) clock cycles. The first decrement lands 2^(code+1) cycles after the write that started the timer.
- R4: In reload mode, a tick at count 0 loads the modulus and sets the flag.
- R5: With reload mode off, a tick at count 0 loads 0xFFFF and sets the flag.
- R6: Writing 1 to bit 2 of offset 0 clears the flag. Writing 0 there leaves the flag unchanged.
- R7: The interrupt equals flag AND interrupt enable. It follows a write or an expiry on the next cycle.
- R8: Any write to offset 2 clears the flag. With overwrite set, the written value becomes the count on the next cycle, in either mode.
- R9: With reload mode on and overwrite off, a modulus write leaves the running count untouched. The new modulus is used at the next expiry.
- R10: A control write whose only change is the interrupt enable (the flag bit aside) does not restart the count or the prescaler.
- R11: A control write that changes any other stored bit loads the count from the new limit (the modulus in reload mode, 0xFFFF otherwise) and restarts the prescaler.
- R12: While enable is 0 the count holds its value.
- R13: Writes to offset 4 have no effect. Reads of any offset other than 0, 2 and 4 return 0.
- R14: If an expiry and a flag-clearing write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | ADDR_W | Byte offset of the register slot |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data is combinational from the registers, so a write or a tick on one clock edge is visible on the read port and the interrupt from that same cycle. Before that edge the old value still shows. The bench drives inputs just after a falling edge. A behavioural model steps once per rising edge. Every register slot and the interrupt are compared against that model at each falling edge, half a cycle after the state moved. Prescaler periods of 2, 4, 8 and 256 cycles are covered, and so are reload wraps, free-running wraps to 0xFFFF and overwrite loads.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int CW    = 16;
    localparam int PRE_W = 4;

    localparam int B_EN   = 0;
    localparam int B_RLD  = 1;
    localparam int B_FLAG = 2;
    localparam int B_IE   = 3;
    localparam int B_OVW  = 4;
    localparam int B_DBG  = 5;
    localparam int B_DOZE = 6;
    localparam int B_PRE  = 8;

    localparam int OFF_CSR = 0;
    localparam int OFF_MOD = 2;
    localparam int OFF_CNT = 4;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             doze;
        logic             dbg;
        logic             ovw;
        logic             ie;
        logic             rld;
        logic             en;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_CSR,
        SEL_MOD,
        SEL_CNT,
        SEL_NONE
    } sel_t;

    function automatic ctrl_t csr_unpack(input logic [CW-1:0] w);
        ctrl_t c;
        c.pre  = w[B_PRE +: PRE_W];
        c.doze = w[B_DOZE];
        c.dbg  = w[B_DBG];
        c.ovw  = w[B_OVW];
        c.ie   = w[B_IE];
        c.rld  = w[B_RLD];
        c.en   = w[B_EN];
        return c;
    endfunction

    function automatic logic [CW-1:0] csr_pack(input ctrl_t c, input logic flag);
        logic [CW-1:0] w;
        w = '0;
        w[B_PRE +: PRE_W] = c.pre;
        w[B_DOZE]         = c.doze;
        w[B_DBG]          = c.dbg;
        w[B_OVW]          = c.ovw;
        w[B_IE]           = c.ie;
        w[B_FLAG]         = flag;
        w[B_RLD]          = c.rld;
        w[B_EN]           = c.en;
        return w;
    endfunction

    // True when two settings differ in anything besides the interrupt enable.
    function automatic logic cfg_differs(input ctrl_t a, input ctrl_t b);
        ctrl_t x;
        x    = a ^ b;
        x.ie = 1'b0;
        return |x;
    endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int PRE_W = pit_pkg::PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             restart,
    input  logic [PRE_W-1:0] code,
    output logic             tick
);
    localparam int PCW = 2 ** PRE_W;

    logic [PCW-1:0] pc_q;
    logic [PCW-1:0] last;

    // Terminal value 2^(code+1)-1 built as a right-shifted mask.
    assign last = {PCW{1'b1}} >> (PRE_W'(PCW - 1) - code);
    assign tick = en && (pc_q == last);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pc_q <= '0;
        end else if (en) begin
            pc_q <= tick ? '0 : pc_q + 1'b1;
        end
    end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
    parameter int CW = pit_pkg::CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          restart,
    input  logic [CW-1:0] restart_val,
    input  logic          force_ld,
    input  logic [CW-1:0] force_val,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] cnt,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    assign cnt    = cnt_q;
    assign expire = tick && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= {CW{1'b1}};
        end else if (restart) begin
            cnt_q <= restart_val;
        end else if (force_ld) begin
            cnt_q <= force_val;
        end else if (tick) begin
            cnt_q <= (cnt_q == '0) ? limit : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  sel_t          sel,
    input  logic [CW-1:0] wdata,
    input  logic          expire,
    output ctrl_t         ctrl,
    output logic          flag,
    output logic [CW-1:0] modulus,
    output logic [CW-1:0] limit,
    output logic          restart,
    output logic [CW-1:0] restart_val,
    output logic          force_ld
);
    ctrl_t         ctrl_q;
    ctrl_t         ctrl_new;
    logic          flag_q;
    logic [CW-1:0] mod_q;
    logic          wr_csr;
    logic          wr_mod;
    logic          clr;

    assign wr_csr   = we && (sel == SEL_CSR);
    assign wr_mod   = we && (sel == SEL_MOD);
    assign ctrl_new = csr_unpack(wdata);
    assign clr      = (wr_csr && wdata[B_FLAG]) || wr_mod;

    assign restart     = wr_csr && cfg_differs(ctrl_q, ctrl_new);
    assign restart_val = ctrl_new.rld ? mod_q : {CW{1'b1}};
    assign force_ld    = wr_mod && ctrl_q.ovw;
    assign limit       = ctrl_q.rld ? mod_q : {CW{1'b1}};

    assign ctrl    = ctrl_q;
    assign flag    = flag_q;
    assign modulus = mod_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            flag_q <= 1'b0;
            mod_q  <= {CW{1'b1}};
        end else begin
            if (wr_csr) begin
                ctrl_q <= ctrl_new;
            end
            if (wr_mod) begin
                mod_q <= wdata;
            end
            flag_q <= (flag_q && !clr) || expire;
        end
    end
endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
    parameter int ADDR_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    output logic               irq_o
);
    import pit_pkg::*;

    sel_t          sel;
    ctrl_t         ctrl_w;
    logic          flag_w;
    logic [CW-1:0] mod_w;
    logic [CW-1:0] limit_w;
    logic          restart_w;
    logic [CW-1:0] restart_val_w;
    logic          force_ld_w;
    logic          tick_w;
    logic          expire_w;
    logic [CW-1:0] cnt_w;

    always_comb begin
        if (bus_addr == ADDR_W'(OFF_CSR))      sel = SEL_CSR;
        else if (bus_addr == ADDR_W'(OFF_MOD)) sel = SEL_MOD;
        else if (bus_addr == ADDR_W'(OFF_CNT)) sel = SEL_CNT;
        else                                   sel = SEL_NONE;
    end

    pit_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .we          (bus_we),
        .sel         (sel),
        .wdata       (bus_wdata),
        .expire      (expire_w),
        .ctrl        (ctrl_w),
        .flag        (flag_w),
        .modulus     (mod_w),
        .limit       (limit_w),
        .restart     (restart_w),
        .restart_val (restart_val_w),
        .force_ld    (force_ld_w)
    );

    pit_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_w.en),
        .restart (restart_w),
        .code    (ctrl_w.pre),
        .tick    (tick_w)
    );

    pit_counter #(.CW(CW)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick_w),
        .restart     (restart_w),
        .restart_val (restart_val_w),
        .force_ld    (force_ld_w),
        .force_val   (bus_wdata),
        .limit       (limit_w),
        .cnt         (cnt_w),
        .expire      (expire_w)
    );

    always_comb begin
        case (sel)
            SEL_CSR: bus_rdata = csr_pack(ctrl_w, flag_w);
            SEL_MOD: bus_rdata = mod_w;
            SEL_CNT: bus_rdata = cnt_w;
            default: bus_rdata = '0;
        endcase
    end

    assign irq_o = flag_w && ctrl_w.ie;
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
    parameter int ADDR_W = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                we,
    input logic [ADDR_W-1:0]   addr,
    input logic [15:0]         wdata,
    input logic [15:0]         rdata,
    input logic                irq,
    input pit_pkg::ctrl_t      ctrl,
    input logic                flag,
    input logic                expire,
    input logic [15:0]         cnt
);
    logic at_csr, at_mod, mapped;
    assign at_csr = (addr == ADDR_W'(0));
    assign at_mod = (addr == ADDR_W'(2));
    assign mapped = at_csr || at_mod || (addr == ADDR_W'(4));

    // R2
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        at_csr |-> (rdata[15:12] == 4'h0 && rdata[7] == 1'b0));

    // R4 and R5
    p_expire_sets_flag_r4: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag);

    // R6
    p_flag_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (we && at_csr && wdata[2] && !expire) |=> !flag);

    // R7
    p_irq_match_r7: assert property (@(posedge clk) disable iff (rst)
        at_csr |-> (irq == (rdata[2] && rdata[3])));

    // R8
    p_ovw_load_r8: assert property (@(posedge clk) disable iff (rst)
        (we && at_mod && ctrl.ovw) |=> (cnt == $past(wdata)));

    // R12
    p_disabled_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && !we) |=> $stable(cnt));

    // R13
    p_unmapped_zero_r13: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> (rdata == 16'h0000));

    // R14
    p_expire_wins_r14: assert property (@(posedge clk) disable iff (rst)
        (expire && we && (at_mod || (at_csr && wdata[2]))) |=> flag);
endmodule

bind pit_timer pit_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .we     (bus_we),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .irq    (irq_o),
    .ctrl   (ctrl_w),
    .flag   (flag_w),
    .expire (expire_w),
    .cnt    (cnt_w)
);

// File: tb/pit_timer_tb.sv
`timescale 1ns/1ps
module pit_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    pit_timer #(.ADDR_W(3)) u_dut (
        .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    // Behavioural reference model, stepped on each rising edge.
    logic [15:0] m_ctrl, m_mod, m_cnt, nv;
    logic        m_flag, tk, ex;
    int          m_pre, div;

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 16'h0; m_mod = 16'hFFFF; m_cnt = 16'hFFFF;
            m_flag = 1'b0; m_pre = 0;
        end else begin
            div = 2 << m_ctrl[11:8];
            tk  = m_ctrl[0] && (m_pre == div - 1);
            ex  = tk && (m_cnt == 16'h0);
            if (m_ctrl[0]) m_pre = tk ? 0 : m_pre + 1;
            if (tk) m_cnt = ex ? (m_ctrl[1] ? m_mod : 16'hFFFF) : m_cnt - 16'h1;
            if (we && addr == 3'd0) begin
                nv = wdata & 16'h0F7B;
                if (wdata[2]) m_flag = 1'b0;
                if (((nv ^ m_ctrl) & ~16'h0008) != 16'h0) begin
                    m_pre = 0;
                    m_cnt = nv[1] ? m_mod : 16'hFFFF;
                end
                m_ctrl = nv;
            end else if (we && addr == 3'd2) begin
                m_mod  = wdata;
                m_flag = 1'b0;
                if (m_ctrl[4]) m_cnt = wdata;
            end
            if (ex) m_flag = 1'b1;
        end
    end

    function automatic logic [15:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0:    return m_ctrl | {13'h0, m_flag, 2'b00};
            3'd2:    return m_mod;
            3'd4:    return m_cnt;
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, half a cycle after each edge.
    always @(negedge clk) begin
        if (!rst) begin
            check(cur_req, rdata, model_rd(addr));
            check(cur_req, {15'h0, irq}, {15'h0, m_flag & m_ctrl[3]});
        end
    end

    logic [2:0] rot [8] = '{3'd0, 3'd2, 3'd4, 3'd1, 3'd4, 3'd0, 3'd6, 3'd2};
    int ridx = 0;

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            we = 1'b0; addr = rot[ridx % 8]; ridx++;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        we = 1'b1; addr = a; wdata = d;
    endtask

    task automatic lit(input string tag, input logic [2:0] a, input logic [15:0] exp);
        @(negedge clk); #1;
        we = 1'b0; addr = a;
        #1 check(tag, rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); #1 rst = 1'b0;
        cur_req = "R1";
        lit("R1", 3'd0, 16'h0000);
        lit("R1", 3'd2, 16'hFFFF);
        lit("R1", 3'd4, 16'hFFFF);
        #1 check("R1", {15'h0, irq}, 16'h0);
        idle(3);

        cur_req = "R2";
        wr(3'd0, 16'hFFFF);
        lit("R2", 3'd0, 16'h0F7B);
        wr(3'd0, 16'h0000);
        idle(4);

        cur_req = "R12";
        idle(20);
        lit("R12", 3'd4, 16'hFFFF);

        cur_req = "R3";
        wr(3'd0, 16'h0201);
        idle(100);
        wr(3'd0, 16'h0001);
        idle(30);

        cur_req = "R8";
        wr(3'd0, 16'h0011);
        wr(3'd2, 16'h0003);
        lit("R8", 3'd4, 16'h0003);
        cur_req = "R5";
        idle(20);

        cur_req = "R10";
        wr(3'd0, 16'h0019);
        idle(6);
        cur_req = "R7";
        idle(6);

        cur_req = "R6";
        wr(3'd0, 16'h0019);
        idle(1);
        lit("R6", 3'd0, 16'h001D);
        wr(3'd0, 16'h001D);
        lit("R6", 3'd0, 16'h0019);
        idle(4);

        cur_req = "R4";
        wr(3'd0, 16'h000B);
        idle(30);

        cur_req = "R9";
        wr(3'd2, 16'h0006);
        idle(40);

        cur_req = "R14";
        wr(3'd0, 16'h001B);
        wr(3'd2, 16'h0002);
        idle(4);
        wr(3'd0, 16'h001F);
        idle(12);

        cur_req = "R11";
        wr(3'd0, 16'h011B);
        idle(30);

        cur_req = "R13";
        wr(3'd4, 16'h1234);
        idle(2);
        lit("R13", 3'd1, 16'h0000);
        lit("R13", 3'd3, 16'h0000);
        lit("R13", 3'd5, 16'h0000);
        lit("R13", 3'd7, 16'h0000);

        cur_req = "R3";
        wr(3'd0, 16'h0701);
        idle(600);
        wr(3'd0, 16'h0000);
        idle(5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule